// File: doc/BRIEF.md
# Pipelined Quadratic Polynomial Evaluator

This block evaluates y = A·x² + B·x + C on signed two's-complement integers of a configurable width. The datapath is fully spatial: it has three multipliers (x·x, B·x and A·x²) and two adders. Delay registers hold the shorter operand paths, so every term of one input set reaches the final sum in the same cycle. As a result, the block accepts a new operand set on every clock and returns one result per clock.

An upstream agent presents A, B, C and x together with a valid strobe. Three cycles later the matching result appears with its own valid strobe. The result width is three times the input width plus two bits, which holds every possible value exactly. Cycles without a valid input create bubbles in the pipeline. These bubbles move through the stages without disturbing the operand sets around them.

The reset input clears the pipeline asynchronously. Its release is re-timed to the clock inside the block.

Top module: `quad_eval`

## Requirements
- R1: When `out_valid` is high, `out_y` equals the exact signed value A·x² + B·x + C of the operand set that was accepted three clock edges earlier. The operands are two's-complement `W`-bit values and the result is a two's-complement `3*W+2`-bit value.
- R2: `out_valid` is high in a cycle exactly when `in_valid` was high at the clock edge three edges before, counted from the release of reset.
- R3: Operand sets presented on consecutive cycles all produce correct results on consecutive cycles, one per clock, with no stall.
- R4: While reset is asserted, `out_valid` is low and `out_y` is zero. Both take effect at once, without waiting for a clock edge.
- R5: In any cycle where `out_valid` is low, `out_y` keeps the last result it showed (zero since reset).
- R6: The most negative and most positive operand values (-128 and 127 at the default width) give exact results with no wrap-around.
- R7: When idle cycles are mixed irregularly with valid operand sets, each result still matches its own operand set, and the results come out in order of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| in_valid | input | 1 | Qualifies the operand set on this cycle |
| in_a | input | W | Coefficient A, signed |
| in_b | input | W | Coefficient B, signed |
| in_c | input | W | Constant term C, signed |
| in_x | input | W | Variable x, signed |
| out_valid | output | 1 | Qualifies out_y |
| out_y | output | 3*W+2 | Result A·x²+B·x+C, signed |

## Verification
The first pattern is a fixed set of hand-computed operand sets sent on back-to-back cycles. It mixes signs, zero terms and sets where only the constant term is non-zero, so a wrong sign extension or a swapped term in one branch shows up as a wrong value. The extreme sets pair -128 and 127 in the products. These separate a correctly sized accumulator from one that wraps around.

A long run of random operands on every cycle checks that the three branches stay aligned at full throughput. A second random run inserts idle cycles irregularly. This shows that bubbles neither shift results onto the wrong operand set nor change the held output.

Finally, reset is asserted in the middle of a stream, with operand sets still in flight. This shows that pending results are dropped and the output returns to zero.

// File: rtl/quad_pkg.sv
package quad_pkg;
  // default operand width and pipeline depth
  localparam int DEF_W   = 8;
  localparam int LATENCY = 3;

  // result width that holds A*x^2 + B*x + C exactly
  function automatic int out_width(input int w);
    return 3 * w + 2;
  endfunction
endpackage

// File: rtl/quad_rst_sync.sv
module quad_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_n;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/quad_mul.sv
module quad_mul #(
  parameter int AW = 8,
  parameter int BW = 8,
  localparam int PW = AW + BW
) (
  input  logic [AW-1:0] op_a,
  input  logic [BW-1:0] op_b,
  output logic [PW-1:0] prod
);
  // signed product, both operands sign-extended to the product width
  always_comb begin
    prod = PW'($signed(op_a) * $signed(op_b));
  end
endmodule

// File: rtl/quad_stage_reg.sv
module quad_stage_reg #(
  parameter int WD = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [WD-1:0] d,
  output logic [WD-1:0] q
);
  logic [WD-1:0] q_n;

  always_comb begin
    q_n = q;
    if (en) q_n = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end
endmodule

// File: rtl/quad_eval.sv
module quad_eval #(
  parameter int W = quad_pkg::DEF_W,
  localparam int OW = quad_pkg::out_width(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic [W-1:0]  in_c,
  input  logic [W-1:0]  in_x,
  output logic          out_valid,
  output logic [OW-1:0] out_y
);
  localparam int P2  = 2 * W;
  localparam int P3  = 3 * W;
  localparam int LAT = quad_pkg::LATENCY;
  localparam int CD  = LAT - 1;  // stages the constant term is held before the sum

  logic srst_n;

  quad_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  // ---------------- valid pipeline ----------------
  logic [LAT:0] vld;
  assign vld[0] = in_valid;

  for (genvar i = 0; i < LAT; i++) begin : g_vld
    quad_stage_reg #(.WD(1)) u_v (
      .clk   (clk),
      .rst_n (srst_n),
      .en    (1'b1),
      .d     (vld[i]),
      .q     (vld[i+1])
    );
  end

  // ---------------- stage 1: x*x and B*x ----------------
  logic [P2-1:0] sq_n, sq_q;
  logic [P2-1:0] bx_n, bx_q1;
  logic [W-1:0]  a_q1;

  quad_mul #(.AW(W), .BW(W)) u_mul_sq (
    .op_a (in_x),
    .op_b (in_x),
    .prod (sq_n)
  );

  quad_mul #(.AW(W), .BW(W)) u_mul_bx (
    .op_a (in_b),
    .op_b (in_x),
    .prod (bx_n)
  );

  quad_stage_reg #(.WD(P2)) u_sq_r (
    .clk (clk), .rst_n (srst_n), .en (vld[0]), .d (sq_n), .q (sq_q)
  );

  quad_stage_reg #(.WD(P2)) u_bx_r1 (
    .clk (clk), .rst_n (srst_n), .en (vld[0]), .d (bx_n), .q (bx_q1)
  );

  quad_stage_reg #(.WD(W)) u_a_r1 (
    .clk (clk), .rst_n (srst_n), .en (vld[0]), .d (in_a), .q (a_q1)
  );

  // constant term travels through CD balancing registers
  logic [W-1:0] c_pipe [CD+1];
  assign c_pipe[0] = in_c;

  for (genvar k = 0; k < CD; k++) begin : g_cdly
    quad_stage_reg #(.WD(W)) u_c (
      .clk   (clk),
      .rst_n (srst_n),
      .en    (vld[k]),
      .d     (c_pipe[k]),
      .q     (c_pipe[k+1])
    );
  end

  // ---------------- stage 2: A*x^2 ----------------
  logic [P3-1:0] ax2_n, ax2_q;
  logic [P2-1:0] bx_q2;

  quad_mul #(.AW(W), .BW(P2)) u_mul_ax2 (
    .op_a (a_q1),
    .op_b (sq_q),
    .prod (ax2_n)
  );

  quad_stage_reg #(.WD(P3)) u_ax2_r (
    .clk (clk), .rst_n (srst_n), .en (vld[1]), .d (ax2_n), .q (ax2_q)
  );

  quad_stage_reg #(.WD(P2)) u_bx_r2 (
    .clk (clk), .rst_n (srst_n), .en (vld[1]), .d (bx_q1), .q (bx_q2)
  );

  // ---------------- stage 3: two adders ----------------
  logic [OW-1:0] ext_ax2, ext_bx, ext_c;
  logic [OW-1:0] part_sum, y_n;

  always_comb begin
    ext_ax2  = {{(OW-P3){ax2_q[P3-1]}}, ax2_q};
    ext_bx   = {{(OW-P2){bx_q2[P2-1]}}, bx_q2};
    ext_c    = {{(OW-W){c_pipe[CD][W-1]}}, c_pipe[CD]};
    part_sum = ext_ax2 + ext_bx;
    y_n      = part_sum + ext_c;
  end

  quad_stage_reg #(.WD(OW)) u_y_r (
    .clk (clk), .rst_n (srst_n), .en (vld[2]), .d (y_n), .q (out_y)
  );

  assign out_valid = vld[LAT];
endmodule

// File: rtl/quad_eval_chk.sv
module quad_eval_chk #(
  parameter int W  = 8,
  parameter int OW = 26
) (
  input logic          clk,
  input logic          srst_n,
  input logic          in_valid,
  input logic [W-1:0]  in_a,
  input logic [W-1:0]  in_b,
  input logic [W-1:0]  in_c,
  input logic [W-1:0]  in_x,
  input logic          out_valid,
  input logic [OW-1:0] out_y
);
  // edges seen since reset release, saturating at the pipeline depth
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)               since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // independent reference, built from the input ports
  logic signed [OW-1:0] ea, eb, ec, ex, ref_y;
  always_comb begin
    ea    = {{(OW-W){in_a[W-1]}}, in_a};
    eb    = {{(OW-W){in_b[W-1]}}, in_b};
    ec    = {{(OW-W){in_c[W-1]}}, in_c};
    ex    = {{(OW-W){in_x[W-1]}}, in_x};
    ref_y = ea * ex * ex + eb * ex + ec;
  end

  // R1
  result_exact_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (since_rst == 2'd3 && out_valid) |-> (out_y == $past(ref_y, 3)));

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R5
  y_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (since_rst == 2'd3 && !$past(in_valid, 3)) |-> $stable(out_y));

  // R4
  always @(posedge clk) begin
    if (!srst_n) begin
      reset_quiet_chk: assert (!out_valid && out_y == '0);
    end
  end
endmodule

bind quad_eval quad_eval_chk #(.W(W), .OW(OW)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .in_valid  (in_valid),
  .in_a      (in_a),
  .in_b      (in_b),
  .in_c      (in_c),
  .in_x      (in_x),
  .out_valid (out_valid),
  .out_y     (out_y)
);

// File: tb/quad_eval_tb.sv
module quad_eval_tb;
  localparam int W  = 8;
  localparam int OW = 3 * W + 2;
  localparam int NV = 9;

  // {a, b, c, x, expected y}
  localparam int VEC [NV][5] = '{
    '{   1,    2,    3,    4,       27},
    '{  -1,    0,    0,    5,      -25},
    '{   3,   -2,    7,   -3,       40},
    '{   0,    0, -128,    0,     -128},
    '{   5,   -7,    0,    1,       -2},
    '{-128, -128, -128, -128, -2080896},
    '{ 127,  127,  127,  127,  2064639},
    '{ 127, -128, -128, -128,  2097024},
    '{-128,  127,  127, -128, -2113281}
  };

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 in_valid;
  logic [W-1:0]         in_a, in_b, in_c, in_x;
  logic                 out_valid;
  logic signed [OW-1:0] out_y;

  int total = 0;
  int bad   = 0;

  // bench model of outstanding results, slot 3 is oldest
  logic   m_v [1:3];
  longint m_y [1:3];
  string  m_t [1:3];
  longint held;

  always #2 clk = ~clk;

  quad_eval #(.W(W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_c      (in_c),
    .in_x      (in_x),
    .out_valid (out_valid),
    .out_y     (out_y)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 1; i <= 3; i++) begin
      m_v[i] = 1'b0; m_y[i] = 0; m_t[i] = "";
    end
    held = 0;
  endtask

  // one cycle: check the output due now, then drive the next operand set
  task automatic step(input logic v, input int a, input int b, input int c,
                      input int x, input longint e, input string req);
    @(negedge clk);
    if (m_v[3]) begin
      check("R2", longint'(out_valid), 1);
      check(m_t[3], longint'(out_y), m_y[3]);
      held = m_y[3];
    end else begin
      check("R2", longint'(out_valid), 0);
      check("R5", longint'(out_y), held);
    end
    m_v[3] = m_v[2]; m_y[3] = m_y[2]; m_t[3] = m_t[2];
    m_v[2] = m_v[1]; m_y[2] = m_y[1]; m_t[2] = m_t[1];
    m_v[1] = v;      m_y[1] = e;      m_t[1] = req;
    in_valid = v;
    in_a = W'(a); in_b = W'(b); in_c = W'(c); in_x = W'(x);
  endtask

  task automatic rand_step(input logic v, input string req);
    int a, b, c, x;
    a = int'($signed(W'($urandom)));
    b = int'($signed(W'($urandom)));
    c = int'($signed(W'($urandom)));
    x = int'($signed(W'($urandom)));
    step(v, a, b, c, x, longint'(a) * x * x + longint'(b) * x + c, req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    check("R4", longint'(out_valid), 0);
    check("R4", longint'(out_y), 0);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_model();
    for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 0, 0, 0, "R5");
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL R3 watchdog actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    in_valid = 1'b0;
    in_a = '0; in_b = '0; in_c = '0; in_x = '0;
    clear_model();
    @(negedge clk);
    do_reset();

    // table of directed vectors, back to back (R1, R3, R6)
    for (int i = 0; i < NV; i++) begin
      step(1'b1, VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3],
           longint'(VEC[i][4]), (i >= 5) ? "R6" : "R1");
    end
    for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 0, 0, 0, "R5");

    // full-rate random stream (R3)
    for (int i = 0; i < 300; i++) rand_step(1'b1, "R3");

    // random stream with irregular bubbles (R7)
    for (int i = 0; i < 300; i++) rand_step(logic'(($urandom % 3) != 0), "R7");

    // reset with results in flight (R4)
    for (int i = 0; i < 2; i++) rand_step(1'b1, "R7");
    @(negedge clk);
    do_reset();

    // traffic resumes correctly after reset (R1)
    step(1'b1, 2, 3, 4, -1, 2 - 3 + 4, "R1");
    for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 0, 0, 0, "R5");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule